// File: doc/BRIEF.md
# Polyphase FIR Tap Address Sequencer

This block walks the taps of one output sample of a sample-rate-converter FIR filter. A pulse on `period_start` marks the start of an output-sample period. On that pulse the block takes a sample-memory start address and a coefficient phase pointer, both supplied by an external servo loop. It then issues one tap per clock. Each tap carries a sample-memory read address, a coefficient address with its fractional phase, and control for one shared multiply-accumulate unit.

The sample address counts down by one per tap. The phase pointer counts up by a step that depends on the rate ratio. The channel's convolution ends on the tap whose advance carries the phase pointer out of its top bit, so the filter lengthens automatically when decimating. The left channel runs first. The same start pointers are then reloaded for the right channel, and a one-cycle strobe tells the accumulator's owner when each channel's sum is ready.

Top module: `polyfir_seq`

## Requirements
- R1: A `period_start` pulse seen while idle starts a convolution. `busy` is high from the next cycle, and the first tap presents `ram_addr` = `ram_start` and {`rom_addr`,`rom_phase`} = `rom_start`.
- R2: On every tap after the first of a channel, `ram_addr` is one less than on the previous tap, wrapping modulo 2^RAM_AW.
- R3: Per tap the phase pointer {`rom_addr`,`rom_phase`} advances by a step in units of 2^-FRAC_W. With `decimate`=1 and 0 < `ratio` <= 2^FRAC_W (1.0), the step is `ratio`. In every other case the step is 2^FRAC_W.
- R4: A channel's last tap is the one whose advance carries out of the PTR_W-bit pointer, so the channel runs ceil((2^PTR_W − `rom_start`)/step) taps.
- R5: The left channel (`mac_chan`=0) is processed first. The right channel (`mac_chan`=1) follows immediately, starting again from the same start pointers.
- R6: `mac_en` is high on every tap cycle and only then. `mac_clr` is high only on the first tap of each channel; it means the accumulator loads the product instead of adding it.
- R7: `result_valid` pulses for one cycle, in the cycle after a channel's last tap, with `result_chan` naming that channel (0 left, 1 right).
- R8: A `period_start` pulse while `busy` is high is ignored: the running convolution and its results are unchanged. `overrun` pulses high in the next cycle.
- R9: `ratio` and `decimate` are sampled only at the accepted `period_start`. Changes during a convolution have no effect on it.
- R10: After reset the block is idle: `busy`, `mac_en`, `mac_clr`, `result_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_start | input | 1 | Start-of-output-period pulse |
| ram_start | input | RAM_AW | Sample-memory start address from the servo loop |
| rom_start | input | COEF_AW+FRAC_W | Coefficient phase pointer start from the servo loop |
| ratio | input | RATIO_W | Output-to-input rate ratio, FRAC_W fraction bits |
| decimate | input | 1 | High when the input rate exceeds the output rate |
| ram_addr | output | RAM_AW | Sample-memory read address of the current tap |
| rom_addr | output | COEF_AW | Coefficient address of the current tap |
| rom_phase | output | FRAC_W | Fractional phase of the current tap |
| mac_en | output | 1 | Tap valid: multiply-accumulate this cycle |
| mac_clr | output | 1 | First tap of a channel: load instead of add |
| mac_chan | output | 1 | Channel of the current tap, 0 left, 1 right |
| result_valid | output | 1 | One-cycle strobe: accumulator holds a finished channel sum |
| result_chan | output | 1 | Channel whose sum is finished |
| busy | output | 1 | Convolution in progress |
| overrun | output | 1 | One-cycle flag: a period start arrived while busy |

## Verification
The bench builds the sequencer with FRAC_W=8, COEF_AW=4 and RAM_AW=5, so a unity-step channel is 16 taps and a half-rate ratio gives 32. With these widths, sample-address wraparound, single-tap channels that sit back to back, and fractional steps that do not divide the pointer range can all be reached in a few hundred cycles. The widths are small enough that every tap's coefficient and sample can be recomputed exactly in the scoreboard. Ratio saturation at zero, at exactly one and above one is reachable through the 12-bit ratio port.

// File: rtl/polyfir_pkg.sv
package polyfir_pkg;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

endpackage

// File: rtl/polyfir_step.sv
// Chooses the per-tap phase increment from the rate ratio.
module polyfir_step #(
    parameter int FRAC_W  = 20,
    parameter int RATIO_W = 24,
    localparam int STEP_W = FRAC_W + 1
) (
    input  logic [RATIO_W-1:0] ratio,
    input  logic               decimate,
    output logic [STEP_W-1:0]  step
);
    localparam logic [RATIO_W-1:0] UNITY_R = RATIO_W'(1) << FRAC_W;
    localparam logic [STEP_W-1:0]  UNITY_S = STEP_W'(1) << FRAC_W;

    logic use_ratio;

    always_comb begin
        // a zero step would never wrap; above one is out of the decimation range
        use_ratio = decimate && (ratio != '0) && (ratio <= UNITY_R);
        step      = use_ratio ? ratio[STEP_W-1:0] : UNITY_S;
    end

endmodule

// File: rtl/polyfir_phase_add.sv
// Phase pointer adder with carry-out used as end-of-channel marker.
module polyfir_phase_add #(
    parameter int PTR_W  = 26,
    parameter int STEP_W = 21
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [STEP_W-1:0] step,
    output logic [PTR_W-1:0]  ptr_next,
    output logic              wrap
);
    logic [PTR_W:0] sum;

    always_comb begin
        sum      = {1'b0, ptr} + {{(PTR_W + 1 - STEP_W){1'b0}}, step};
        ptr_next = sum[PTR_W-1:0];
        wrap     = sum[PTR_W];
    end

endmodule

// File: rtl/polyfir_seq.sv
module polyfir_seq
    import polyfir_pkg::*;
#(
    parameter int RAM_AW  = 8,
    parameter int COEF_AW = 6,
    parameter int FRAC_W  = 20,
    parameter int RATIO_W = 24,
    localparam int PTR_W  = COEF_AW + FRAC_W,
    localparam int STEP_W = FRAC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               period_start,
    input  logic [RAM_AW-1:0]  ram_start,
    input  logic [PTR_W-1:0]   rom_start,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               decimate,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [COEF_AW-1:0] rom_addr,
    output logic [FRAC_W-1:0]  rom_phase,
    output logic               mac_en,
    output logic               mac_clr,
    output logic               mac_chan,
    output logic               result_valid,
    output logic               result_chan,
    output logic               busy,
    output logic               overrun
);
    localparam logic [STEP_W-1:0] UNITY_S = STEP_W'(1) << FRAC_W;

    typedef struct packed {
        logic              busy;
        chan_e             chan;
        logic              first;
        logic [RAM_AW-1:0] ram_ptr;
        logic [RAM_AW-1:0] ram_base;
        logic [PTR_W-1:0]  rom_ptr;
        logic [PTR_W-1:0]  rom_base;
        logic [STEP_W-1:0] step;
        logic              valid;
        chan_e             vchan;
        logic              ovr;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [STEP_W-1:0] step_sel;
    logic [PTR_W-1:0]  rom_adv;
    logic              rom_wrap;

    polyfir_step #(
        .FRAC_W  (FRAC_W),
        .RATIO_W (RATIO_W)
    ) u_step (
        .ratio    (ratio),
        .decimate (decimate),
        .step     (step_sel)
    );

    polyfir_phase_add #(
        .PTR_W  (PTR_W),
        .STEP_W (STEP_W)
    ) u_phase (
        .ptr      (st_q.rom_ptr),
        .step     (st_q.step),
        .ptr_next (rom_adv),
        .wrap     (rom_wrap)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ovr   = 1'b0;
        st_d.first = 1'b0;
        if (!st_q.busy) begin
            if (period_start) begin
                st_d.busy     = 1'b1;
                st_d.chan     = CH_LEFT;
                st_d.first    = 1'b1;
                st_d.ram_ptr  = ram_start;
                st_d.ram_base = ram_start;
                st_d.rom_ptr  = rom_start;
                st_d.rom_base = rom_start;
                st_d.step     = step_sel;
            end
        end else begin
            st_d.ovr = period_start;
            if (rom_wrap) begin
                st_d.valid = 1'b1;
                st_d.vchan = st_q.chan;
                if (st_q.chan == CH_LEFT) begin
                    st_d.chan    = CH_RIGHT;
                    st_d.first   = 1'b1;
                    st_d.ram_ptr = st_q.ram_base;
                    st_d.rom_ptr = st_q.rom_base;
                end else begin
                    st_d.busy = 1'b0;
                end
            end else begin
                st_d.ram_ptr = st_q.ram_ptr - 1'b1;
                st_d.rom_ptr = rom_adv;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_addr     = st_q.ram_ptr;
    assign rom_addr     = st_q.rom_ptr[PTR_W-1:FRAC_W];
    assign rom_phase    = st_q.rom_ptr[FRAC_W-1:0];
    assign mac_en       = st_q.busy;
    assign mac_clr      = st_q.busy & st_q.first;
    assign mac_chan     = st_q.chan;
    assign result_valid = st_q.valid;
    assign result_chan  = st_q.vchan;
    assign busy         = st_q.busy;
    assign overrun      = st_q.ovr;

    // R2: sample address steps down by one between taps of a channel
    assert_ram_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !rom_wrap) |=> (ram_addr == $past(ram_addr) - 1'b1));

    // R3: phase pointer advances by the latched step between taps
    assert_rom_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !rom_wrap) |=>
        ({rom_addr, rom_phase} == $past({rom_addr, rom_phase}) + PTR_W'($past(st_q.step))));

    // R3: the latched step is never zero and never above one
    assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.step != '0 && st_q.step <= UNITY_S));

    // R5: left channel wrap hands over to a cleared right channel
    assert_right_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && rom_wrap && st_q.chan == CH_LEFT) |=>
        (mac_en && mac_clr && mac_chan == 1'b1));

    // R6: a clear never comes without a tap
    assert_clr_on_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mac_clr |-> mac_en);

    // R7: a result strobe always follows a tap cycle
    assert_valid_after_tap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(mac_en));

    // R8: a start while busy raises overrun and leaves the start pointers alone
    assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && period_start) |=>
        (overrun && $stable(st_q.rom_base) && $stable(st_q.ram_base)));

endmodule

// File: tb/polyfir_seq_test.sv
module polyfir_seq_test;
    localparam int RAM_AW  = 5;
    localparam int COEF_AW = 4;
    localparam int FRAC_W  = 8;
    localparam int RATIO_W = 12;
    localparam int PTR_W   = COEF_AW + FRAC_W;
    localparam int UNITY   = 1 << FRAC_W;
    localparam int PTR_TOP = 1 << PTR_W;
    localparam int RAM_MSK = (1 << RAM_AW) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               period_start = 1'b0;
    logic [RAM_AW-1:0]  ram_start = '0;
    logic [PTR_W-1:0]   rom_start = '0;
    logic [RATIO_W-1:0] ratio = '0;
    logic               decimate = 1'b0;
    logic [RAM_AW-1:0]  ram_addr;
    logic [COEF_AW-1:0] rom_addr;
    logic [FRAC_W-1:0]  rom_phase;
    logic               mac_en, mac_clr, mac_chan;
    logic               result_valid, result_chan, busy, overrun;

    polyfir_seq #(
        .RAM_AW (RAM_AW), .COEF_AW (COEF_AW), .FRAC_W (FRAC_W), .RATIO_W (RATIO_W)
    ) uut (
        .clk (clk), .rst_n (rst_n), .period_start (period_start),
        .ram_start (ram_start), .rom_start (rom_start), .ratio (ratio),
        .decimate (decimate), .ram_addr (ram_addr), .rom_addr (rom_addr),
        .rom_phase (rom_phase), .mac_en (mac_en), .mac_clr (mac_clr),
        .mac_chan (mac_chan), .result_valid (result_valid),
        .result_chan (result_chan), .busy (busy), .overrun (overrun)
    );

    always #10 clk = ~clk;

    typedef struct {
        int     chan;
        longint sum;
        int     taps;
        int     ram0;
        int     rom0;
    } exp_t;

    exp_t   expq[$];
    int     checks = 0;
    int     errors = 0;
    longint acc = 0;
    int     tapcnt = 0;
    int     prev_ram = 0;

    function automatic int coef(int a);
        return a * 3 + 1;
    endfunction

    function automatic int samp(int chan, int a);
        return (chan == 0) ? (a + 7) : (3 * a + 2);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected per-channel sum and tap count, from R2..R4
    task automatic push_expect(input int r0, input int p0, input int rat, input bit dec);
        int step;
        step = (dec && rat != 0 && rat <= UNITY) ? rat : UNITY;
        for (int ch = 0; ch < 2; ch++) begin
            exp_t e;
            int p, r;
            e.chan = ch; e.sum = 0; e.taps = 0; e.ram0 = r0; e.rom0 = p0;
            p = p0; r = r0;
            do begin
                e.sum += longint'(coef(p >> FRAC_W)) * samp(ch, r);
                e.taps++;
                r = (r - 1) & RAM_MSK;
                p += step;
            end while (p < PTR_TOP);
            expq.push_back(e);
        end
    endtask

    task automatic launch(input int r0, input int p0, input int rat, input bit dec);
        push_expect(r0, p0, rat, dec);
        @(negedge clk);
        ram_start = RAM_AW'(r0); rom_start = PTR_W'(p0);
        ratio = RATIO_W'(rat); decimate = dec; period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: MAC and memory model plus scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (result_valid) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R7 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(result_chan == e.chan[0], "R7 result_chan", result_chan, e.chan);
                    check(acc == e.sum, "R3 channel sum", acc, e.sum);
                    check(tapcnt == e.taps, "R4 tap count", tapcnt, e.taps);
                end
            end
            if (mac_en) begin
                if (mac_clr) begin
                    if (expq.size() != 0) begin
                        check(mac_chan == expq[0].chan[0], "R5 channel order", mac_chan, expq[0].chan);
                        check(int'(ram_addr) == expq[0].ram0, "R1 first ram_addr", ram_addr, expq[0].ram0);
                        check(int'({rom_addr, rom_phase}) == expq[0].rom0, "R1 first rom pointer",
                              {rom_addr, rom_phase}, expq[0].rom0);
                    end
                    acc = 0;
                    tapcnt = 0;
                end else begin
                    check(int'(ram_addr) == ((prev_ram - 1) & RAM_MSK), "R2 ram step",
                          ram_addr, (prev_ram - 1) & RAM_MSK);
                end
                acc += longint'(coef(int'(rom_addr))) * samp(int'(mac_chan), int'(ram_addr));
                tapcnt++;
                prev_ram = int'(ram_addr);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R10 busy", busy, 0);
        check(!mac_en && !mac_clr, "R10 mac_en/mac_clr", {mac_en, mac_clr}, 0);
        check(!result_valid, "R10 result_valid", result_valid, 0);
        check(!overrun, "R10 overrun", overrun, 0);

        // R1 R4: unity step from zero, ram wraps below 0
        launch(10, 0, 0, 1'b0);
        check(busy, "R1 busy after start", busy, 1);
        wait_idle();
        // R4: fractional start phase, still 16 taps
        launch(31, 128, 0, 1'b0); wait_idle();
        // R4 R7: single-tap channels, back-to-back strobes
        launch(3, PTR_TOP - UNITY + 5, 0, 1'b0); wait_idle();
        // R3: half ratio doubles the length
        launch(20, 0, 128, 1'b1); wait_idle();
        // R3 R4: non-dividing ratio and start
        launch(7, 37, 100, 1'b1); wait_idle();
        // R3: saturation cases
        launch(5, 0, 0, 1'b1); wait_idle();
        launch(5, 0, 768, 1'b1); wait_idle();
        launch(5, 0, 128, 1'b0); wait_idle();
        launch(12, 300, 256, 1'b1); wait_idle();

        // R8: start while busy is ignored and flagged
        launch(9, 0, 128, 1'b1);
        repeat (4) @(negedge clk);
        check(!overrun, "R8 no overrun before", overrun, 0);
        ram_start = 5'd1; rom_start = 12'd2000; period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        check(overrun, "R8 overrun pulse", overrun, 1);
        @(negedge clk);
        check(!overrun, "R8 overrun one cycle", overrun, 0);
        wait_idle();

        // R9: ratio change mid-run has no effect
        launch(17, 64, 128, 1'b1);
        repeat (3) @(negedge clk);
        ratio = 12'd256; decimate = 1'b0;
        wait_idle();

        check(expq.size() == 0, "R7 all results seen", expq.size(), 0);
        check(!busy && !mac_en, "R6 idle after run", {busy, mac_en}, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule